// File: doc/BRIEF.md
# Mode-Steered Four-Pin Port Controller

This block controls one narrow pin port of a microcontroller. The port has four usable pins. A three-bit operating mode is captured while reset is held. The mode decides what each pin may carry: a line of the external address bus, a general-purpose output, or a general-purpose input. Software reaches three registers over a simple synchronous bus: a direction register, a data register and an input pull-up enable register. Each register sits at its own 20-bit address.

The chip supplies the address bus value on `addr_line`. In the locked modes (1 to 4), all four pins drive address lines and the direction bits cannot be changed. In mode 5, a pin whose direction bit is set drives its address line, and any other pin is an input. In the remaining modes (0, 6 and 7), a set direction bit makes the pin a general-purpose output driven from the data register. Pin levels reach the data register read path through a two-flop synchronizer.

Top module: `pinport_ctl`

## Requirements
- R1: After reset, the data and pull-up registers read 0xF0. `pin_oe` is 0xF in modes 1 to 4 and 0x0 in every other mode.
- R2: Reading the direction register (address 0xEE004) always returns 0xFF, in every mode, whatever has been written to it.
- R3: In modes 1 to 4, `pin_oe` is 0xF and `pin_out` equals `addr_line`. Writes to the direction register change neither of them. `pin_pu` stays 0.
- R4: In mode 5, pin p has `pin_oe[p]` equal to direction bit p (the low four bits of the last direction write). When that bit is 1, `pin_out[p]` equals `addr_line[p]`.
- R5: In modes 0, 6 and 7, pin p has `pin_oe[p]` equal to direction bit p. When that bit is 1, `pin_out[p]` equals data register bit p.
- R6: A pin whose `pin_oe` bit is 0 drives `pin_out` low.
- R7: Bits 7 to 4 of the data register (address 0xFFFD4) and of the pull-up register (address 0xEE03F) read as 1 and ignore writes. Bits 3 to 0 of both registers store what is written.
- R8: A data register read returns, for each of bits 3 to 0, the stored bit when the pin is an output and the synchronized pin level when it is an input. A `pin_in` change sampled at one clock edge appears in a read issued at the edge two clocks later.
- R9: `pin_pu[p]` is 1 only when pull-up bit p is 1, the pin is not an output and the mode is 0, 5, 6 or 7.
- R10: `bus_rdata` is valid in the cycle after `bus_re` and is 0 in any cycle that follows no read, and after a read of an unmapped address. A read and a write in the same cycle return the value held before the write.
- R11: The mode is taken from `mode_i` only while `rst_n` is low. Changes of `mode_i` after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; mode is captured while low |
| mode_i | input | 3 | Chip operating mode |
| bus_addr | input | 20 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, one cycle after the strobe |
| pin_in | input | 4 | Pad input levels, asynchronous |
| addr_line | input | 4 | Address bus bits offered to the pins |
| pin_out | output | 4 | Value driven onto each pin |
| pin_oe | output | 4 | Output enable per pin |
| pin_pu | output | 4 | Pull-up enable per pin |

## Verification
Two events can fall in the same cycle: a register read and a write to that same register, and a data register read while the pin levels are moving through the synchronizer. The bench issues read and write strobes together on the data register and on the pull-up register. It expects the pre-write value back, then the new value on the next read. It toggles `pin_in` on every cycle of the run, so that data reads catch pins set as inputs mid-transition. A behavioural model that keeps the synchronizer as a two-entry history judges each result.

// File: rtl/pinport_pkg.sv
package pinport_pkg;

   typedef enum logic [1:0] {
      PM_ADDR_LOCK = 2'd0,
      PM_ADDR_OPT  = 2'd1,
      PM_GPIO      = 2'd2
   } port_role_e;

   function automatic port_role_e role_of(input logic [2:0] mode);
      if (mode >= 3'd1 && mode <= 3'd4) return PM_ADDR_LOCK;
      else if (mode == 3'd5)            return PM_ADDR_OPT;
      else                              return PM_GPIO;
   endfunction

endpackage

// File: rtl/pinport_sync.sv
module pinport_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pinport_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pinport_regs.sv
module pinport_regs
   import pinport_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 8,
   parameter int PIN_N  = 4,
   parameter logic [ADDR_W-1:0] DIR_ADDR = 20'hEE004,
   parameter logic [ADDR_W-1:0] DAT_ADDR = 20'hFFFD4,
   parameter logic [ADDR_W-1:0] PU_ADDR  = 20'hEE03F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_i,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [PIN_N-1:0]  pin_sync,
   output logic [DATA_W-1:0] bus_rdata,
   output port_role_e        role,
   output logic [PIN_N-1:0]  eff_dir,
   output logic [PIN_N-1:0]  dat_q,
   output logic [PIN_N-1:0]  pu_q
);
   localparam int RESV_W = DATA_W - PIN_N;

   if (PIN_N < 1 || PIN_N >= DATA_W) begin : g_bad_width
      $error("pinport_regs: PIN_N must be between 1 and DATA_W-1");
   end

   logic [2:0]        mode_q;
   logic [PIN_N-1:0]  dir_q;
   logic [DATA_W-1:0] rd_val;
   logic              hit_dir, hit_dat, hit_pu;
   logic              unused_wdata_hi;

   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:PIN_N];

   // mode is only sampled while reset is asserted
   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= mode_i;
   end

   assign role    = role_of(mode_q);
   assign eff_dir = (role == PM_ADDR_LOCK) ? '1 : dir_q;

   assign hit_dir = (bus_addr == DIR_ADDR);
   assign hit_dat = (bus_addr == DAT_ADDR);
   assign hit_pu  = (bus_addr == PU_ADDR);

   always_comb begin
      rd_val = '0;
      if (hit_dir)
         rd_val = '1;
      else if (hit_dat)
         rd_val = {{RESV_W{1'b1}}, (eff_dir & dat_q) | (~eff_dir & pin_sync)};
      else if (hit_pu)
         rd_val = {{RESV_W{1'b1}}, pu_q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q     <= '0;
         dat_q     <= '0;
         pu_q      <= '0;
         bus_rdata <= '0;
      end else begin
         if (bus_we) begin
            if (hit_dir && role != PM_ADDR_LOCK) dir_q <= bus_wdata[PIN_N-1:0];
            if (hit_dat)                         dat_q <= bus_wdata[PIN_N-1:0];
            if (hit_pu)                          pu_q  <= bus_wdata[PIN_N-1:0];
         end
         bus_rdata <= bus_re ? rd_val : '0;
      end
   end
endmodule

// File: rtl/pinport_mux.sv
module pinport_mux
   import pinport_pkg::*;
#(
   parameter int PIN_N = 4
) (
   input  port_role_e       role,
   input  logic [PIN_N-1:0] eff_dir,
   input  logic [PIN_N-1:0] dat_q,
   input  logic [PIN_N-1:0] pu_q,
   input  logic [PIN_N-1:0] addr_line,
   output logic [PIN_N-1:0] pin_out,
   output logic [PIN_N-1:0] pin_oe,
   output logic [PIN_N-1:0] pin_pu
);
   logic use_addr, pu_allow;

   assign use_addr = (role != PM_GPIO);
   assign pu_allow = (role != PM_ADDR_LOCK);

   for (genvar p = 0; p < PIN_N; p++) begin : g_pin
      assign pin_oe[p]  = eff_dir[p];
      assign pin_out[p] = eff_dir[p] & (use_addr ? addr_line[p] : dat_q[p]);
      assign pin_pu[p]  = pu_q[p] & ~eff_dir[p] & pu_allow;
   end
endmodule

// File: rtl/pinport_ctl.sv
module pinport_ctl
   import pinport_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int DATA_W      = 8,
   parameter int PIN_N       = 4,
   parameter int SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] DIR_ADDR = 20'hEE004,
   parameter logic [ADDR_W-1:0] DAT_ADDR = 20'hFFFD4,
   parameter logic [ADDR_W-1:0] PU_ADDR  = 20'hEE03F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_i,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [PIN_N-1:0]  pin_in,
   input  logic [PIN_N-1:0]  addr_line,
   output logic [PIN_N-1:0]  pin_out,
   output logic [PIN_N-1:0]  pin_oe,
   output logic [PIN_N-1:0]  pin_pu
);
   if (DIR_ADDR == DAT_ADDR || DIR_ADDR == PU_ADDR || DAT_ADDR == PU_ADDR) begin : g_bad_map
      $error("pinport_ctl: register addresses must differ");
   end

   port_role_e       role;
   logic [PIN_N-1:0] pin_sync, eff_dir, dat_q, pu_q;

   pinport_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
   );

   pinport_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_N(PIN_N),
      .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR), .PU_ADDR(PU_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
      .pin_sync(pin_sync), .bus_rdata(bus_rdata),
      .role(role), .eff_dir(eff_dir), .dat_q(dat_q), .pu_q(pu_q)
   );

   pinport_mux #(.PIN_N(PIN_N)) u_mux (
      .role(role), .eff_dir(eff_dir), .dat_q(dat_q), .pu_q(pu_q),
      .addr_line(addr_line),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
   );
endmodule

// File: rtl/pinport_chk.sv
module pinport_chk #(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 8,
   parameter int PIN_N  = 4,
   parameter logic [ADDR_W-1:0] DIR_ADDR = 20'hEE004
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        mode_i,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_re,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [PIN_N-1:0]  addr_line,
   input logic [PIN_N-1:0]  pin_out,
   input logic [PIN_N-1:0]  pin_oe,
   input logic [PIN_N-1:0]  pin_pu
);
   logic [2:0] ck_mode;
   logic       ck_lock, ck_m5;

   always_ff @(posedge clk) begin
      if (!rst_n) ck_mode <= mode_i;
   end
   assign ck_lock = (ck_mode >= 3'd1) && (ck_mode <= 3'd4);
   assign ck_m5   = (ck_mode == 3'd5);

   AST_LOCK_ALL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      ck_lock |-> (pin_oe == '1 && pin_pu == '0)); // R3

   AST_ADDR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ck_m5 |-> (((pin_out ^ addr_line) & pin_oe) == '0)); // R4

   AST_IDLE_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out & ~pin_oe) == '0)); // R6

   AST_PU_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_pu & pin_oe) == '0)); // R9

   AST_DIR_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr == DIR_ADDR) |=> (bus_rdata == '1)); // R2

   AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> (bus_rdata == '0)); // R10
endmodule

bind pinport_ctl pinport_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_N(PIN_N), .DIR_ADDR(DIR_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .bus_addr(bus_addr),
   .bus_re(bus_re), .bus_rdata(bus_rdata), .addr_line(addr_line),
   .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
);

// File: tb/tb_pinport_ctl.sv
`timescale 1ns/1ps
module tb_pinport_ctl;
   localparam logic [19:0] A_DIR = 20'hEE004;
   localparam logic [19:0] A_DAT = 20'hFFFD4;
   localparam logic [19:0] A_PU  = 20'hEE03F;
   localparam logic [19:0] A_NONE = 20'h12345;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_i = 3'd6;
   logic [19:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_we = 1'b0, bus_re = 1'b0;
   logic [7:0]  bus_rdata;
   logic [3:0]  pin_in = '0, addr_line = '0;
   logic [3:0]  pin_out, pin_oe, pin_pu;

   int total = 0, bad = 0, cyc = 0;

   always #4 clk = ~clk;

   pinport_ctl dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .addr_line(addr_line),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
   );

   // behavioural reference model
   int       m_mode;
   bit [3:0] m_dir, m_dat, m_pu;
   bit [3:0] hist[$];
   bit [7:0] m_rd;
   string    m_rtag = "R10";

   function automatic bit m_lock();
      return m_mode >= 1 && m_mode <= 4;
   endfunction
   function automatic bit [3:0] m_eff();
      return m_lock() ? 4'hF : m_dir;
   endfunction
   function automatic bit [7:0] m_read(input logic [19:0] a);
      if (a == A_DIR) return 8'hFF;
      if (a == A_DAT) return {4'hF, (m_eff() & m_dat) | (~m_eff() & hist[0])};
      if (a == A_PU)  return {4'hF, m_pu};
      return 8'h00;
   endfunction

   always @(posedge clk) begin
      bit [7:0] rdv;
      if (!rst_n) begin
         m_mode = int'(mode_i);
         m_dir = 0; m_dat = 0; m_pu = 0; m_rd = 0;
         hist = '{4'h0, 4'h0};
         m_rtag = "R10";
      end else begin
         rdv = bus_re ? m_read(bus_addr) : 8'h00;
         m_rtag = !bus_re ? "R10" : (bus_addr == A_DIR) ? "R2" :
                  (bus_addr == A_DAT) ? "R8" : (bus_addr == A_PU) ? "R7" : "R10";
         if (bus_we) begin
            if (bus_addr == A_DIR && !m_lock()) m_dir = bus_wdata[3:0];
            if (bus_addr == A_DAT) m_dat = bus_wdata[3:0];
            if (bus_addr == A_PU)  m_pu  = bus_wdata[3:0];
         end
         void'(hist.pop_front());
         hist.push_back(pin_in);
         m_rd = rdv;
      end
   end

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // compare against model on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         string ptag;
         bit [3:0] e_out, e_pu;
         ptag = m_lock() ? "R3 pins" : (m_mode == 5) ? "R4 pins" : "R5 pins";
         e_out = m_eff() & ((m_lock() || m_mode == 5) ? addr_line : m_dat);
         e_pu  = m_pu & ~m_eff() & (m_lock() ? 4'h0 : 4'hF);
         check({ptag, " oe"}, {4'h0, pin_oe}, {4'h0, m_eff()});
         check({ptag, " out"}, {4'h0, pin_out}, {4'h0, e_out});
         check("R9 pull-up", {4'h0, pin_pu}, {4'h0, e_pu});
         check({m_rtag, " rdata"}, bus_rdata, m_rd);
      end
   end

   // pins and address lines keep moving on every cycle
   always @(negedge clk) begin
      #2;
      pin_in    <= pin_in + 4'd3;
      addr_line <= addr_line ^ {pin_in[0], pin_in[3:1]} ^ 4'h9;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic bus_wr(input logic [19:0] a, input logic [7:0] d);
      @(negedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [19:0] a, output logic [7:0] d);
      @(negedge clk); #1;
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      d = bus_rdata;
      #1 bus_re = 1'b0;
   endtask

   task automatic bus_rw(input logic [19:0] a, input logic [7:0] wd, output logic [7:0] d);
      @(negedge clk); #1;
      bus_addr = a; bus_wdata = wd; bus_we = 1'b1; bus_re = 1'b1;
      @(negedge clk);
      d = bus_rdata;
      #1 bus_we = 1'b0; bus_re = 1'b0;
   endtask

   initial begin
      logic [7:0] rd;
      for (int m = 0; m < 8; m++) begin
         @(negedge clk); #1;
         rst_n = 1'b0; mode_i = 3'(m);
         repeat (3) @(negedge clk);
         #1 rst_n = 1'b1;
         @(negedge clk);
         check("R1 oe after reset", {4'h0, pin_oe}, (m >= 1 && m <= 4) ? 8'h0F : 8'h00);
         bus_rd(A_PU, rd);  check("R1 pull-up reset", rd, 8'hF0);
         bus_rd(A_DIR, rd); check("R2 dir read", rd, 8'hFF);
         bus_wr(A_DIR, 8'h05);
         bus_rd(A_DIR, rd); check("R2 dir read after write", rd, 8'hFF);
         @(negedge clk);
         check("R3 R4 R5 oe after dir write", {4'h0, pin_oe},
               (m >= 1 && m <= 4) ? 8'h0F : 8'h05);
         bus_wr(A_DAT, 8'h0A);
         bus_wr(A_PU, 8'h0F);
         repeat (6) begin
            bus_rd(A_DAT, rd);
         end
         bus_wr(A_PU, 8'h00);
         bus_rd(A_PU, rd); check("R7 pull-up upper bits", rd, 8'hF0);
         bus_wr(A_PU, 8'hA6);
         bus_rd(A_PU, rd); check("R7 pull-up store", rd, 8'hF6);
         bus_rd(A_NONE, rd); check("R10 unmapped read", rd, 8'h00);
         bus_wr(A_DIR, 8'h0F);
         bus_rw(A_DAT, 8'h03, rd);
         check("R10 read-write collision old value", rd,
               (m == 5 || m == 0 || m >= 6) ? 8'hFA : 8'hFA);
         bus_rd(A_DAT, rd); check("R10 value after collision", rd, 8'hF3);
         bus_rw(A_PU, 8'h01, rd); check("R10 pull-up collision", rd, 8'hF6);
         @(negedge clk);
         check("R6 idle pins low", {4'h0, pin_out & ~pin_oe}, 8'h00);
         // mode changes after reset are ignored
         mode_i = (m >= 1 && m <= 4) ? 3'd6 : 3'd2;
         bus_wr(A_DIR, 8'h00);
         @(negedge clk);
         check("R11 mode held after reset", {4'h0, pin_oe},
               (m >= 1 && m <= 4) ? 8'h0F : 8'h00);
         mode_i = 3'(m);
         repeat (2) @(negedge clk);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule